// File: doc/BRIEF.md
# Two-Point Linear Calibration Unit

This block corrects the gain and offset error of an N-bit converter using two reference conversions. One is taken with the input at one quarter of full scale and one at three quarters. When a calibrate strobe arrives with these two readings, the block computes a fixed-point gain, with 1,000,000 standing for unity, and a signed offset. It uses one shared multi-cycle divider for both. Each raw sample is then reduced to N bits and corrected as floor(raw × gain / 1,000,000) + offset. The result is saturated to the converter range.

The corrected stream has a fixed two-cycle latency. While the coefficients are being computed, the calibration-done flag is low and incoming samples are discarded. A calibration whose upper reading does not exceed its lower reading is refused. In that case an error flag is raised and the coefficients in use stay as they were.

Top module: `twopt_cal_unit`

## Requirements
- R1: After reset, cal_done is 1, cal_err is 0 and out_valid is 0. The gain is 1,000,000 and the offset is 0.
- R2: With the reset coefficients, every accepted raw value appears unchanged on out_data.
- R3: Only in_raw bits [N-1:0] take part in correction; the bits above them have no effect on out_data.
- R4: A sample accepted at a rising edge (in_valid high while cal_done is 1) produces out_valid with its result exactly two rising edges later.
- R5: A cal_start seen while cal_done is 1 and ref_hi > ref_lo drops cal_done at that edge. The block then sets gain = (2^N/2 × 1,000,000) / (ref_hi − ref_lo) and offset = 2^N/4 − (ref_lo × gain) / 1,000,000, both truncating, and raises cal_done again.
- R6: A cal_start seen while cal_done is 1 and ref_hi ≤ ref_lo sets cal_err at that edge. cal_done stays 1 and both coefficients are kept.
- R7: An accepted calibration clears cal_err.
- R8: in_valid while cal_done is 0 is ignored: no out_valid results from it.
- R9: out_data is floor(raw × gain / 1,000,000) + offset, forced to 0 when negative and to 2^N − 1 when larger than that.
- R10: cal_start while cal_done is 0 is ignored; the running calibration finishes with its own readings.
- R11: A sample accepted in the same cycle as an accepted cal_start is corrected with the coefficients in force before that calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_start | input | 1 | One-cycle strobe to compute coefficients from ref_lo and ref_hi |
| ref_lo | input | N | Conversion taken at one quarter of full scale |
| ref_hi | input | N | Conversion taken at three quarters of full scale |
| in_valid | input | 1 | Raw sample present |
| in_raw | input | RAW_W | Raw sample; only the low N bits are used |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | N | Corrected, saturated sample |
| cal_done | output | 1 | Coefficients settled; samples are accepted |
| cal_err | output | 1 | Last calibration request was refused |

## Verification
The one overlap this block allows is a sample and a calibration strobe arriving in the same cycle while the unit is idle. The sample is accepted, and the calibration begins at that same edge. The bench provokes this by raising cal_start and in_valid together. It then judges the resulting output against the coefficients in force before the strobe, and judges the samples after cal_done returns against the new ones. Exhaustive sweeps of every raw code, under calibrations that include identity, steep gain with heavy saturation, and the narrowest span, show the arithmetic and clamping. Strobes and samples injected during the busy window show they are ignored.

// File: rtl/twopt_cal_pkg.sv
`timescale 1ns/1ps
package twopt_cal_pkg;
  // coefficient engine phases
  typedef enum logic [1:0] {
    CE_IDLE  = 2'd0,
    CE_GAIN  = 2'd1,
    CE_OFFS  = 2'd2
  } ce_state_e;
endpackage

// File: rtl/cal_seq_divider.sv
`timescale 1ns/1ps
// Unsigned restoring divider, one quotient bit per cycle, W cycles per run.
module cal_seq_divider #(
  parameter int W = 39
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, fin_q, fin_d;
  logic [W:0]    shifted;
  logic          step_en;

  assign step_en = go | busy_q;

  always_comb begin
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    fin_d   = 1'b0;
    shifted = {rem_q, quo_q[W-1]};
    if (go) begin
      rem_d  = '0;
      quo_d  = dividend;
      dvs_d  = divisor;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (shifted >= {1'b0, dvs_q}) begin
        rem_d = W'(shifted - {1'b0, dvs_q});
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(W - 1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      if (step_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        dvs_q <= dvs_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign quo = quo_q;
  assign fin = fin_q;

  // a finished division leaves a remainder below the divisor (R5)
  assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < dvs_q));
endmodule

// File: rtl/cal_coeff_engine.sv
`timescale 1ns/1ps
// Computes gain and offset from the two reference readings.
module cal_coeff_engine
  import twopt_cal_pkg::*;
#(
  parameter int N     = 10,
  parameter int UNITY = 1000000,
  parameter int SW    = 29,
  parameter int PW    = 39,
  parameter int BW    = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N-1:0]         ref_lo,
  input  logic [N-1:0]         ref_hi,
  output logic [SW-1:0]        scale,
  output logic signed [BW-1:0] bias,
  output logic                 done,
  output logic                 err
);
  localparam logic [PW-1:0]        UNITY_W = PW'(UNITY);
  localparam logic [PW-1:0]        SPAN_X  = UNITY_W << (N - 1);
  localparam logic signed [BW-1:0] NOM0_S  = BW'(1 << (N - 2));

  ce_state_e            st_q, st_d;
  logic [N-1:0]         lo_q, lo_d;
  logic [SW-1:0]        scale_q, scale_d;
  logic signed [BW-1:0] bias_q, bias_d;
  logic                 err_q, err_d;
  logic                 accept, good;
  logic                 div_go, div_fin;
  logic [PW-1:0]        div_dend, div_dvs, div_quo;
  logic [PW-2*N-1:0]    unused_quo_hi;

  assign accept        = start && (st_q == CE_IDLE);
  assign good          = ref_hi > ref_lo;
  assign unused_quo_hi = div_quo[PW-1:2*N];

  always_comb begin
    st_d     = st_q;
    lo_d     = lo_q;
    scale_d  = scale_q;
    bias_d   = bias_q;
    err_d    = err_q;
    div_go   = 1'b0;
    div_dend = SPAN_X;
    div_dvs  = PW'(ref_hi - ref_lo);
    unique case (st_q)
      CE_IDLE: begin
        if (accept) begin
          if (good) begin
            div_go = 1'b1;
            lo_d   = ref_lo;
            err_d  = 1'b0;
            st_d   = CE_GAIN;
          end else begin
            err_d  = 1'b1;
          end
        end
      end
      CE_GAIN: begin
        div_dend = PW'(lo_q) * PW'(div_quo[SW-1:0]);
        div_dvs  = UNITY_W;
        if (div_fin) begin
          scale_d = div_quo[SW-1:0];
          div_go  = 1'b1;
          st_d    = CE_OFFS;
        end
      end
      CE_OFFS: begin
        if (div_fin) begin
          bias_d = NOM0_S - $signed({1'b0, div_quo[2*N-1:0]});
          st_d   = CE_IDLE;
        end
      end
      default: st_d = CE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CE_IDLE;
      lo_q    <= '0;
      scale_q <= SW'(UNITY);
      bias_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      lo_q    <= lo_d;
      scale_q <= scale_d;
      bias_q  <= bias_d;
      err_q   <= err_d;
    end
  end

  cal_seq_divider #(.W(PW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dend),
    .divisor  (div_dvs),
    .quo      (div_quo),
    .fin      (div_fin)
  );

  assign scale = scale_q;
  assign bias  = bias_q;
  assign done  = (st_q == CE_IDLE);
  assign err   = err_q;

  assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && good) |=> !done);
  assert_refused_keeps_coef_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !good) |=> (err_q && done && $stable(scale_q) && $stable(bias_q)));
  assert_err_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && good) |=> !err_q);
  assert_start_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (st_q != CE_IDLE)) |=> ($stable(lo_q) && $stable(err_q)));
endmodule

// File: rtl/cal_sample_path.sv
`timescale 1ns/1ps
// Two-stage correction: multiply by gain, then divide by unity, add offset, saturate.
module cal_sample_path #(
  parameter int N     = 10,
  parameter int RAW_W = 16,
  parameter int UNITY = 1000000,
  parameter int SW    = 29,
  parameter int PW    = 39,
  parameter int BW    = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [RAW_W-1:0]     in_raw,
  input  logic [SW-1:0]        scale,
  input  logic signed [BW-1:0] bias,
  output logic                 out_valid,
  output logic [N-1:0]         out_data
);
  localparam int                     SUMW     = BW + 1;
  localparam logic [RAW_W-1:0]       RAW_MASK = RAW_W'((1 << N) - 1);
  localparam logic [PW-1:0]          UNITY_W  = PW'(UNITY);
  localparam logic signed [SUMW-1:0] MAX_S    = SUMW'((1 << N) - 1);

  logic [PW-1:0]          prod_d, prod_q, quo;
  logic                   vld1_q, vld2_q;
  logic [N-1:0]           data_d, data_q;
  logic signed [SUMW-1:0] sum;
  logic [PW-2*N-1:0]      unused_quo_hi;

  always_comb begin
    prod_d = PW'(in_raw & RAW_MASK) * PW'(scale);
    quo    = prod_q / UNITY_W;
    sum    = $signed({2'b00, quo[2*N-1:0]}) + $signed({bias[BW-1], bias});
    if (sum < 0)
      data_d = '0;
    else if (sum > MAX_S)
      data_d = MAX_S[N-1:0];
    else
      data_d = sum[N-1:0];
  end

  assign unused_quo_hi = quo[PW-1:2*N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1_q <= 1'b0;
      vld2_q <= 1'b0;
      prod_q <= '0;
      data_q <= '0;
    end else begin
      vld1_q <= in_valid;
      vld2_q <= vld1_q;
      if (in_valid) prod_q <= prod_d;
      if (vld1_q)   data_q <= data_d;
    end
  end

  assign out_valid = vld2_q;
  assign out_data  = data_q;

  assert_clamp_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld1_q && (sum < 0)) |=> (data_q == '0));
  assert_clamp_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld1_q && (sum > MAX_S)) |=> (data_q == MAX_S[N-1:0]));
endmodule

// File: rtl/twopt_cal_unit.sv
`timescale 1ns/1ps
module twopt_cal_unit #(
  parameter int N     = 10,
  parameter int RAW_W = 16,
  parameter int UNITY = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic [N-1:0]     ref_lo,
  input  logic [N-1:0]     ref_hi,
  input  logic             in_valid,
  input  logic [RAW_W-1:0] in_raw,
  output logic             out_valid,
  output logic [N-1:0]     out_data,
  output logic             cal_done,
  output logic             cal_err
);
  localparam int UW = $clog2(UNITY + 1);
  localparam int SW = N - 1 + UW;   // gain width
  localparam int PW = N + SW;       // product / divider width
  localparam int BW = 2 * N + 1;    // signed offset width

  logic [1:0]           rs_q;
  logic                 rst_i;
  logic                 take;
  logic [SW-1:0]        scale;
  logic signed [BW-1:0] bias;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign take = in_valid & cal_done;

  cal_coeff_engine #(.N(N), .UNITY(UNITY), .SW(SW), .PW(PW), .BW(BW)) u_coef (
    .clk    (clk),
    .rst_n  (rst_i),
    .start  (cal_start),
    .ref_lo (ref_lo),
    .ref_hi (ref_hi),
    .scale  (scale),
    .bias   (bias),
    .done   (cal_done),
    .err    (cal_err)
  );

  cal_sample_path #(.N(N), .RAW_W(RAW_W), .UNITY(UNITY), .SW(SW), .PW(PW), .BW(BW)) u_path (
    .clk       (clk),
    .rst_n     (rst_i),
    .in_valid  (take),
    .in_raw    (in_raw),
    .scale     (scale),
    .bias      (bias),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assert_latency_two_R4: assert property (@(posedge clk) disable iff (!rst_i)
    take |-> ##2 out_valid);
  assert_no_stray_output_R8: assert property (@(posedge clk) disable iff (!rst_i)
    !take |-> ##2 !out_valid);
endmodule

// File: tb/twopt_cal_unit_tb.sv
`timescale 1ns/1ps
module twopt_cal_unit_tb;
  localparam int N     = 10;
  localparam int RAW_W = 16;
  localparam longint U = 1000000;
  localparam longint FS = longint'(1) << N;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cal_start;
  logic [N-1:0]     ref_lo, ref_hi;
  logic             in_valid;
  logic [RAW_W-1:0] in_raw;
  logic             out_valid;
  logic [N-1:0]     out_data;
  logic             cal_done, cal_err;

  int total = 0;
  int bad   = 0;
  longint m_scale = U;
  longint m_bias  = 0;
  longint expq[$];
  int stray = 0;

  always #2 clk = ~clk;

  twopt_cal_unit #(.N(N), .RAW_W(RAW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .ref_lo(ref_lo),
    .ref_hi(ref_hi), .in_valid(in_valid), .in_raw(in_raw),
    .out_valid(out_valid), .out_data(out_data), .cal_done(cal_done), .cal_err(cal_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expv(input longint r);
    longint t;
    t = (r * m_scale) / U + m_bias;
    if (t < 0) t = 0;
    if (t > FS - 1) t = FS - 1;
    return t;
  endfunction

  function automatic void model_cal(input longint lo, input longint hi);
    m_scale = ((3 * FS / 4 - FS / 4) * U) / (hi - lo);
    m_bias  = FS / 4 - (lo * m_scale) / U;
  endfunction

  // output monitor: every result is compared with the queued expectation (R9, R8)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        stray++;
        chk(1'b0, "R8 output without accepted sample", longint'(out_data), -1);
      end else begin
        longint e;
        e = expq.pop_front();
        chk(longint'(out_data) == e, "R9 corrected value", longint'(out_data), e);
      end
    end
  end

  task automatic sweep(input string tag);
    for (int i = 0; i < (1 << N); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_raw   = {6'($urandom), N'(i)};   // R3: junk in the upper bits
      expq.push_back(expv(i));
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!cal_done && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(cal_done == 1'b1, "R5 calibration completes", cal_done, 1);
  endtask

  // accepted calibration, with samples and a second strobe injected while busy
  task automatic calibrate(input int lo, input int hi);
    int s0;
    @(negedge clk);
    cal_start = 1'b1; ref_lo = N'(lo); ref_hi = N'(hi);
    @(negedge clk);
    cal_start = 1'b0;
    chk(cal_done == 1'b0, "R5 cal_done drops", cal_done, 0);
    chk(cal_err == 1'b0, "R7 accepted start clears error", cal_err, 0);
    s0 = stray;
    for (int j = 0; j < 6; j++) begin
      in_valid = 1'b1; in_raw = RAW_W'($urandom);          // R8: must be ignored
      cal_start = (j == 2); ref_lo = 0; ref_hi = N'(FS - 1); // R10: must be ignored
      @(negedge clk);
    end
    in_valid = 1'b0; cal_start = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    chk(stray == s0, "R8 no output while busy", stray - s0, 0);
    model_cal(lo, hi);
  endtask

  task automatic refuse(input int lo, input int hi);
    @(negedge clk);
    cal_start = 1'b1; ref_lo = N'(lo); ref_hi = N'(hi);
    @(negedge clk);
    cal_start = 1'b0;
    chk(cal_err == 1'b1, "R6 refused calibration flags error", cal_err, 1);
    chk(cal_done == 1'b1, "R6 cal_done stays high", cal_done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cal_start = 1'b0; ref_lo = '0; ref_hi = '0;
    in_valid = 1'b0; in_raw = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cal_done == 1'b1, "R1 cal_done after reset", cal_done, 1);
    chk(cal_err == 1'b0, "R1 cal_err after reset", cal_err, 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    // R2/R3 identity pass-through over every code
    sweep("R2 identity sweep drained");

    // R4 latency of a single sample
    @(negedge clk);
    in_valid = 1'b1; in_raw = RAW_W'(37); expq.push_back(expv(37));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R4 no output after one edge", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 output after two edges", out_valid, 1);
    repeat (2) @(negedge clk);

    // R5 exact quarter/three-quarter readings keep identity
    calibrate(256, 768);
    sweep("R5 identity calibration sweep");

    // R5/R9 ordinary correction
    calibrate(200, 900);
    sweep("R9 gain 0.73 sweep");

    // R6 refusals keep coefficients
    refuse(400, 400);
    sweep("R6 coefficients kept after equal readings");
    refuse(700, 300);
    sweep("R6 coefficients kept after inverted readings");

    // R9 steep gain, saturation at both ends; R7 clears error
    calibrate(500, 520);
    sweep("R9 saturating sweep");

    // R11 coincident sample and strobe
    @(negedge clk);
    cal_start = 1'b1; ref_lo = 0; ref_hi = N'(FS - 1);
    in_valid = 1'b1; in_raw = RAW_W'(510);
    expq.push_back(expv(510));   // old coefficients (R11)
    @(negedge clk);
    cal_start = 1'b0; in_valid = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R11 coincident sample delivered", expq.size(), 0);
    model_cal(0, FS - 1);
    sweep("R9 full-span sweep");

    // narrowest span at the top of the range
    calibrate(int'(FS - 2), int'(FS - 1));
    sweep("R9 unit-span sweep");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule